// File: doc/BRIEF.md
# Sign-Aware Barrel Shifter

This block shifts an operand by a variable amount and reports when a left shift loses signed information. Five operations are offered. Two are plain left and right logical shifts. The third is a right shift that copies the sign. The fourth is a left shift that pins the top bit in place and moves only the bits below it. The fifth is a left shift that clamps to the signed extremes instead of wrapping.

All left operations compare the bits that leave the word, and the bit that lands in the sign position, with the original sign. From that comparison they raise an overflow flag. A fault output repeats that flag when the caller enables it. The shifted result is always delivered, faulting or not.

The shift is combinational. Each accepted request is captured into output registers on the next clock edge, along with a matching valid.

Top module: `sign_shift_top`

## Requirements
- R1: Op code 3'b000 (logical left) yields the operand shifted up by the amount, with zeros entering at bit 0. An amount of WIDTH or more gives zero.
- R2: Op code 3'b001 (logical right) yields the operand shifted down, with zeros entering at the top. An amount of WIDTH or more gives zero.
- R3: Op code 3'b010 (arithmetic right) fills every vacated upper bit with the operand's original top bit. An amount of WIDTH or more gives all copies of that bit.
- R4: Op code 3'b011 (sign-holding left) passes the top bit through unchanged and shifts bits WIDTH-2..0 up, with zero fill. For example, 0xC0000000 by 1 gives 0x80000000, and 0x80000000 by 1 gives 0x80000000.
- R5: Op code 3'b100 (saturating left) gives the logical left result when there is no overflow. On overflow it gives 0x7FF..F for a non-negative operand and 0x800..0 for a negative one. For example, 0x40000000 by 1 gives 0x7FFFFFFF.
- R6: For the three left ops with amount k, overflow is high exactly when the top k+1 operand bits are not all equal. For k of WIDTH or more, overflow is high exactly when the operand is nonzero. The right ops never raise overflow.
- R7: The fault output equals overflow AND the fault-enable input. The result output is the same whether fault-enable is high or low.
- R8: An amount of zero returns the operand unchanged, with overflow low, for every op.
- R9: Op codes 3'b101 to 3'b111 return the operand unchanged, with overflow low.
- R10: The outputs are registered one clock after a request with in_valid high, and out_valid is high for that cycle only. While in_valid is low, result, overflow and fault hold their values.
- R11: A synchronous active-high reset clears out_valid, result, overflow and fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_operand | input | WIDTH | Value to shift |
| in_amt | input | AMT_W | Shift amount |
| in_op | input | 3 | Operation code |
| in_fault_en | input | 1 | Enables the fault output |
| out_valid | output | 1 | Result registered this cycle |
| out_result | output | WIDTH | Shifted result |
| out_ovf | output | 1 | Signed overflow of a left shift |
| out_fault | output | 1 | Overflow gated by the enable |

## Verification
Every result, flag and the output valid is due on the first rising edge after the request edge. The bench drives a request on a falling edge and samples at the following falling edge, which is half a cycle after the capture edge. It then drops in_valid, changes the data inputs, and samples again one cycle later to confirm that the outputs have held.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [2:0] {
        OP_LSL  = 3'b000,
        OP_LSR  = 3'b001,
        OP_ASR  = 3'b010,
        OP_HOLD = 3'b011,
        OP_SAT  = 3'b100
    } shift_op_e;

    function automatic logic is_left(input logic [2:0] op);
        return (op == OP_LSL) || (op == OP_HOLD) || (op == OP_SAT);
    endfunction

    function automatic logic is_right(input logic [2:0] op);
        return (op == OP_LSR) || (op == OP_ASR);
    endfunction

endpackage

// File: rtl/shift_left_unit.sv
module shift_left_unit #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 6
) (
    input  logic [WIDTH-1:0] operand,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] lsl_res,
    output logic [WIDTH-1:0] hold_res,
    output logic [WIDTH-1:0] sat_res,
    output logic             ovf
);
    localparam logic [WIDTH-1:0] SMAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] SMIN = {1'b1, {(WIDTH-1){1'b0}}};

    logic             too_far;
    logic [WIDTH-1:0] undo;
    logic [WIDTH-2:0] low_shift;

    always_comb begin
        too_far   = (32'(amt) >= WIDTH);
        lsl_res   = too_far ? '0 : (operand << amt);
        undo      = WIDTH'($signed(lsl_res) >>> amt);
        ovf       = (undo != operand);
        low_shift = operand[WIDTH-2:0] << amt;
        hold_res  = {operand[WIDTH-1], low_shift};
        sat_res   = ovf ? (operand[WIDTH-1] ? SMIN : SMAX) : lsl_res;
    end
endmodule

// File: rtl/shift_right_unit.sv
module shift_right_unit #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 6
) (
    input  logic [WIDTH-1:0] operand,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] lsr_res,
    output logic [WIDTH-1:0] asr_res
);
    logic too_far;

    always_comb begin
        too_far = (32'(amt) >= WIDTH);
        lsr_res = too_far ? '0 : (operand >> amt);
        asr_res = too_far ? {WIDTH{operand[WIDTH-1]}}
                          : WIDTH'($signed(operand) >>> amt);
    end
endmodule

// File: rtl/sign_shift_top.sv
module sign_shift_top
    import shift_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_operand,
    input  logic [AMT_W-1:0] in_amt,
    input  logic [2:0]       in_op,
    input  logic             in_fault_en,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_result,
    output logic             out_ovf,
    output logic             out_fault
);
    logic [WIDTH-1:0] lsl_res, hold_res, sat_res, lsr_res, asr_res;
    logic             left_ovf;
    logic [WIDTH-1:0] nxt_res;
    logic             nxt_ovf;
    shift_op_e        op;

    shift_left_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W)) left_i (
        .operand(in_operand), .amt(in_amt), .lsl_res(lsl_res),
        .hold_res(hold_res), .sat_res(sat_res), .ovf(left_ovf)
    );

    shift_right_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W)) right_i (
        .operand(in_operand), .amt(in_amt),
        .lsr_res(lsr_res), .asr_res(asr_res)
    );

    always_comb begin
        op      = shift_op_e'(in_op);
        nxt_ovf = is_left(in_op) && left_ovf;
        case (op)
            OP_LSL:  nxt_res = lsl_res;
            OP_LSR:  nxt_res = lsr_res;
            OP_ASR:  nxt_res = asr_res;
            OP_HOLD: nxt_res = hold_res;
            OP_SAT:  nxt_res = sat_res;
            default: nxt_res = in_operand;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_ovf    <= 1'b0;
            out_fault  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= nxt_res;
                out_ovf    <= nxt_ovf;
                out_fault  <= nxt_ovf && in_fault_en;
            end
        end
    end

    AST_FAULT_NEEDS_OVF: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> out_ovf); // R7
    AST_ZERO_AMT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_amt == '0) |=> (!out_ovf && out_result == $past(in_operand))); // R8
    AST_HOLD_SIGN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'b011) |=> (out_result[WIDTH-1] == $past(in_operand[WIDTH-1]))); // R4
    AST_RIGHT_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_right(in_op)) |=> !out_ovf); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_ovf))); // R10
    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'b100 && $signed(in_operand) >= 0) |=>
        (out_result[WIDTH-1] == 1'b0 || out_result == '0)); // R5
endmodule

// File: tb/sign_shift_top_tb_top.sv
module sign_shift_top_tb_top;
    localparam int W  = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [W-1:0]  in_operand;
    logic [AW-1:0] in_amt;
    logic [2:0]    in_op;
    logic          in_fault_en;
    logic          out_valid;
    logic [W-1:0]  out_result;
    logic          out_ovf;
    logic          out_fault;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sign_shift_top #(.WIDTH(W), .AMT_W(AW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_amt(in_amt), .in_op(in_op), .in_fault_en(in_fault_en),
        .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf),
        .out_fault(out_fault)
    );

    function automatic logic exp_ovf(input logic [2:0] op, input logic [W-1:0] x, input int k);
        logic bad = 1'b0;
        if (!(op == 3'd0 || op == 3'd3 || op == 3'd4) || k == 0) return 1'b0;
        if (k >= W) return (x != '0);
        for (int i = W - 1 - k; i < W; i++) if (x[i] != x[W-1]) bad = 1'b1;
        return bad;
    endfunction

    function automatic logic [W-1:0] exp_res(input logic [2:0] op, input logic [W-1:0] x, input int k);
        logic [W-1:0] r = '0;
        case (op)
            3'd0: for (int i = 0; i < W; i++) r[i] = (i >= k) ? x[i-k] : 1'b0;
            3'd1: for (int i = 0; i < W; i++) r[i] = (i + k < W) ? x[i+k] : 1'b0;
            3'd2: for (int i = 0; i < W; i++) r[i] = (i + k < W) ? x[i+k] : x[W-1];
            3'd3: begin
                r[W-1] = x[W-1];
                for (int i = 0; i < W - 1; i++) r[i] = (i >= k) ? x[i-k] : 1'b0;
            end
            3'd4: begin
                if (exp_ovf(op, x, k)) r = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
                else for (int i = 0; i < W; i++) r[i] = (i >= k) ? x[i-k] : 1'b0;
            end
            default: r = x;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [2:0] op, input int k);
        if (k == 0) return "R8";
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [W-1:0] x, input int k, input logic en);
        logic [W-1:0] er;
        logic         eo;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_operand = x; in_amt = AW'(k); in_fault_en = en;
        er = exp_res(op, x, k);
        eo = exp_ovf(op, x, k);
        @(negedge clk);
        in_valid = 1'b0;
        check(req_of(op, k), out_result, er);
        check("R6", W'(out_ovf), W'(eo));
        check("R7", W'(out_fault), W'(eo && en));
        check("R10", W'(out_valid), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        logic         held_ovf;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; in_valid = 1'b0; in_operand = '1; in_amt = '0; in_op = '0; in_fault_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", {out_valid, out_ovf, out_fault}, '0);
        check("R11", out_result, '0);
        rst = 1'b0;

        run(3'd3, 32'hC000_0000, 1, 1'b1);              // R4 example
        run(3'd3, 32'h8000_0000, 1, 1'b1);              // R4 example with overflow
        run(3'd4, 32'h4000_0000, 1, 1'b0);              // R5 positive clamp
        run(3'd4, 32'hA000_0000, 2, 1'b1);              // R5 negative clamp
        run(3'd0, 32'hFFFF_FFFF, 31, 1'b1);             // R6 just fits
        run(3'd0, 32'h0000_0001, 40, 1'b1);             // R1 R6 full shift-out
        run(3'd1, 32'h8000_0000, 32, 1'b0);             // R2 full shift-out
        run(3'd2, 32'h8000_0000, 63, 1'b1);             // R3 all sign
        run(3'd2, 32'h8000_0000, 4, 1'b1);              // R3
        run(3'd3, 32'h8000_0001, 35, 1'b1);             // R4 sign only
        run(3'd0, 32'h1234_5678, 0, 1'b1);              // R8
        run(3'd6, 32'hDEAD_BEEF, 5, 1'b1);              // R9
        run(3'd5, 32'h8000_0000, 9, 1'b1);              // R9
        run(3'd0, 32'h4000_0000, 1, 1'b0);              // R7 masked fault
        run(3'd0, 32'h4000_0000, 1, 1'b1);              // R7 enabled fault

        for (int n = 0; n < 400; n++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            int         k  = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 63) : $urandom_range(0, 33);
            logic [W-1:0] x = $urandom;
            if ($urandom_range(0, 3) == 0) x = {W{x[0]}} ^ W'(x[3:0]);
            run(op, x, k, 1'($urandom));
        end

        // R10: idle cycle keeps the outputs
        run(3'd0, 32'h4000_0000, 1, 1'b1);
        held = out_result; held_ovf = out_ovf;
        in_operand = 32'h0000_00FF; in_op = 3'd1; in_amt = 6'd3;
        @(negedge clk);
        check("R10", W'(out_valid), 0);
        check("R10", out_result, held);
        check("R10", W'(out_ovf), W'(held_ovf));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule